// File: doc/BRIEF.md
# Clocked Byte Serial Port

This block is a synchronous serial port that moves one byte at a time between a small CPU and an outside device. It has three serial pins: a data input, a data output and a shift clock. The shift clock can be driven by the port or taken from the pin. The CPU uses three operations. A write places a byte in the shift register. A start launches the transfer. The register can then be read back at any time, and after a transfer it holds the byte that came in.

In internal-clock mode the port generates the shift clock from the core clock. The clock idles high, and each half period lasts `SCK_HALF` core cycles. In external-clock mode the pin clock passes through a synchroniser, together with the data input, before its edges are detected. In both modes, outgoing data changes only after falling clock edges and incoming data is captured on rising edges. Bits travel most significant first. When the eighth rising edge arrives, busy drops, a done pulse lasting one cycle is issued, and the interrupt request flag is set. The flag stays set until the CPU clears it.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, rd_data_o is 0, busy_o, done_o and irq_o are 0, sck_o is 1 and sdo_o is 1.
- R2: While busy_o is 0, a write (wr_en_i high) loads wr_data_i into the shift register, and rd_data_o shows it from the next cycle.
- R3: While busy_o is 1, a write and a start are both ignored: the bits sent, the transfer length and the received byte are unchanged.
- R4: Bits are sent MSB first. sdo_o changes only in the cycle after a detected falling shift-clock edge, and after falling edge k (counting from 0) it carries bit 7-k of the byte that was written.
- R5: On each rising shift-clock edge the serial input bit is shifted into bit 0. After eight rising edges, rd_data_o holds the received byte, with the first received bit in bit 7.
- R6: In internal-clock mode (ext_sck_sel_i=0 at start), sck_oe_o is 1 and sck_o idles high. During a transfer sck_o makes exactly 8 low pulses, and falling edges are 2*SCK_HALF cycles apart.
- R7: In external-clock mode (ext_sck_sel_i=1 at start), sck_oe_o is 0 and shifting follows sck_i after a two-flop synchroniser. sck_i edges seen while idle change nothing.
- R8: busy_o is high for exactly 16*SCK_HALF cycles of an internal transfer. busy_o falls in the same cycle that done_o pulses high, and done_o is high for one cycle.
- R9: done sets irq_o. irq_o holds until irq_clr_i, and a done in the same cycle as a clear leaves irq_o set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core (instruction cycle) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write command |
| wr_data_i | input | 8 | Byte to load |
| start_i | input | 1 | Start command |
| ext_sck_sel_i | input | 1 | 1 selects the external shift clock |
| irq_clr_i | input | 1 | Clears the interrupt request |
| rd_data_o | output | 8 | Shift register contents |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| irq_o | output | 1 | Interrupt request flag |
| sck_i | input | 1 | Shift clock from pin |
| sck_o | output | 1 | Generated shift clock |
| sck_oe_o | output | 1 | Shift clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The bench injects a write and a start partway through a transfer. A design that did not block them would send altered bits after that point or stretch the busy window. Every cycle it checks that sdo_o moves only after falling edges, which exposes output that shifts on the wrong edge or in LSB-first order. It holds irq_clr_i high through the completion cycle, so a clear that wins over the set would leave irq_o low when done_o fires. Stray external clock toggles while idle must leave the register unchanged, and an off-by-one bit counter shows up as a wrong pulse count or a wrong busy length.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/ssp_clk_gen.sv
module ssp_clk_gen #(
  parameter int unsigned SCK_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ext_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o,
  output logic sdi_o
);
  localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

  logic [DIV_W-1:0]       div_q;
  logic                   sck_q;
  logic                   tick;
  logic [SYNC_STAGES-1:0] sck_sync_q;
  logic [SYNC_STAGES-1:0] sdi_sync_q;
  logic                   sck_prev_q;
  logic                   ext_sck;

  assign tick = (div_q == DIV_LAST);

  // internal divider: runs only while a transfer in internal mode is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i || ext_i) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_sync_q <= '1;
          sdi_sync_q <= '0;
        end else begin
          sck_sync_q <= {sck_sync_q[SYNC_STAGES-2:0], sck_i};
          sdi_sync_q <= {sdi_sync_q[SYNC_STAGES-2:0], sdi_i};
        end
      end
    end else begin : g_sync_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_sync_q <= '1;
          sdi_sync_q <= '0;
        end else begin
          sck_sync_q <= sck_i;
          sdi_sync_q <= sdi_i;
        end
      end
    end
  endgenerate

  assign ext_sck = sck_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b1;
    else         sck_prev_q <= ext_sck;
  end

  always_comb begin
    fall_o = 1'b0;
    rise_o = 1'b0;
    if (run_i) begin
      if (ext_i) begin
        fall_o = sck_prev_q && !ext_sck;
        rise_o = !sck_prev_q && ext_sck;
      end else begin
        fall_o = tick && sck_q;
        rise_o = tick && !sck_q;
      end
    end
  end

  assign sdi_o = ext_i ? sdi_sync_q[SYNC_STAGES-1] : sdi_i;
  assign sck_o = sck_q;

  AST_INT_SCK_HIGH_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sck_o); // R6
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic              sdo_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b1;
    end else begin
      if (load_i) shreg_q <= data_i;
      else if (rise_i) shreg_q <= {shreg_q[DATA_W-2:0], sdi_i};
      if (start_i) cnt_q <= '0;
      else if (rise_i) cnt_q <= cnt_q + 1'b1;
      if (fall_i) sdo_q <= shreg_q[DATA_W-1];
    end
  end

  assign last_o  = rise_i && (cnt_q == CNT_LAST);
  assign shreg_o = shreg_q;
  assign sdo_o   = sdo_q;

  AST_SHREG_FROZEN_BETWEEN_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rise_i |=> $stable(shreg_q)); // R3
  AST_SDO_MOVES_ON_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdo_q)); // R4
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SCK_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              ext_sck_sel_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o
);
  clk_src_e src_q;
  logic     busy_q, done_q, irq_q;
  logic     start_ok, load_ok;
  logic     fall, rise, sdi_sel, last;

  assign start_ok = start_i && !busy_q;
  assign load_ok  = wr_en_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= CLK_INT;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (start_ok) begin
        src_q  <= ext_sck_sel_i ? CLK_EXT : CLK_INT;
        busy_q <= 1'b1;
      end else if (last) begin
        busy_q <= 1'b0;
      end
      done_q <= last;
      // set has priority over clear
      irq_q  <= last || (irq_q && !irq_clr_i);
    end
  end

  ssp_clk_gen #(
    .SCK_HALF   (SCK_HALF),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_clk_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .ext_i (src_q == CLK_EXT),
    .sck_i (sck_i),
    .sdi_i (sdi_i),
    .sck_o (sck_o),
    .fall_o(fall),
    .rise_o(rise),
    .sdi_o (sdi_sel)
  );

  ssp_shifter #(
    .DATA_W(DATA_W)
  ) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_q),
    .load_i (load_ok),
    .data_i (wr_data_i),
    .start_i(start_ok),
    .fall_i (fall),
    .rise_i (rise),
    .sdi_i  (sdi_sel),
    .shreg_o(rd_data_o),
    .sdo_o  (sdo_o),
    .last_o (last)
  );

  assign sck_oe_o = busy_q ? (src_q == CLK_INT) : !ext_sck_sel_i;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !busy_q && $past(busy_q)); // R8
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> irq_q); // R9
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sck_o); // R6
endmodule

// File: tb/test_serial_shift_port.sv
module test_serial_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int EXT_HALF   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, start = 1'b0, ext_sel = 1'b0, irq_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       busy, done, irq, sck_in = 1'b1, sck_out, sck_oe, sdi = 1'b0, sdo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  serial_shift_port #(.DATA_W(8), .SCK_HALF(HALF), .SYNC_STAGES(2)) i_serial_shift_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .start_i(start),
    .ext_sck_sel_i(ext_sel), .irq_clr_i(irq_clr), .rd_data_o(rd_data), .busy_o(busy),
    .done_o(done), .irq_o(irq), .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .sdi_i(sdi), .sdo_o(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bit_of(input logic [7:0] b, input int k);
    return b[7-k];
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == b, "R2 load", rd_data, b);
  endtask

  // internal-clock transfer; bench acts as the remote slave
  task automatic run_int(input logic [7:0] tx, input logic [7:0] rx, input bit inject, input bit hold_clr);
    int nf = 0, nr = 0, busy_cnt = 0, done_cnt = 0, last_fall = -1, post = 0;
    bit prev_sck, prev_sdo, sdo_bad = 0, period_bad = 0, oe_bad = 0;
    write_byte(tx);
    ext_sel = 1'b0; start = 1'b1; irq_clr = hold_clr;
    @(negedge clk);
    start = 1'b0;
    prev_sck = 1'b1; prev_sdo = sdo;
    for (int c = 0; c < 400; c++) begin
      if (busy) busy_cnt++;
      if (busy && !sck_oe) oe_bad = 1;
      if (prev_sck && !sck_out) begin
        check(sdo == bit_of(tx, nf), "R4 msb-first bit", sdo, bit_of(tx, nf));
        if (last_fall >= 0 && c - last_fall != 2*HALF) period_bad = 1;
        last_fall = c;
        sdi = bit_of(rx, nf);
        nf++;
      end else if (sdo != prev_sdo) begin
        sdo_bad = 1;
      end
      if (!prev_sck && sck_out) nr++;
      if (done) begin
        done_cnt++;
        check(irq == 1'b1, "R9 irq set on done (set wins)", irq, 1);
      end
      if (inject && c == 5) begin
        wr_en = 1'b1; wr_data = ~tx; start = 1'b1;
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      prev_sck = sck_out; prev_sdo = sdo;
      if (done_cnt > 0) post++;
      if (post > 3) break;
      @(negedge clk);
    end
    wr_en = 1'b0; start = 1'b0;
    check(!sdo_bad, "R4 sdo only after falling edge", sdo_bad, 0);
    check(!oe_bad, "R6 sck_oe high in internal mode", oe_bad, 0);
    check(!period_bad, "R6 sck period", period_bad, 0);
    check(nf == 8 && nr == 8, "R6 eight sck pulses", nf*16+nr, 8*16+8);
    check(busy_cnt == 16*HALF, inject ? "R3 start while busy ignored" : "R8 busy length", busy_cnt, 16*HALF);
    check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    check(rd_data == rx, inject ? "R3 write while busy ignored" : "R5 received byte", rd_data, rx);
    check(irq == !hold_clr, "R9 irq after transfer", irq, !hold_clr);
    irq_clr = 1'b0;
  endtask

  task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx);
    write_byte(tx);
    ext_sel = 1'b1; sck_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b0; sdi = bit_of(rx, k);
      repeat (EXT_HALF) @(negedge clk);
      check(sdo == bit_of(tx, k), "R7 ext sdo bit", sdo, bit_of(tx, k));
      check(sck_oe == 1'b0 && busy == 1'b1, "R7 ext clock not driven", {sck_oe, busy}, 1);
      sck_in = 1'b1;
      repeat (EXT_HALF) @(negedge clk);
    end
    check(busy == 1'b0, "R7 ext transfer ends", busy, 0);
    check(rd_data == rx, "R7 ext received byte", rd_data, rx);
    check(irq == 1'b1, "R9 irq after ext transfer", irq, 1);
    ext_sel = 1'b0;
  endtask

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'h1c0ffee));
    #(3*CLK_PERIOD);
    @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check({busy, done, irq} == 3'b000, "R1 flags", {busy, done, irq}, 0);
    check(sck_out == 1'b1 && sdo == 1'b1, "R1 sck/sdo", {sck_out, sdo}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck_out == 1'b1 && !busy, "R6 idle sck high", sck_out, 1);

    run_int(8'hA5, 8'h3C, 1'b0, 1'b0);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
    @(negedge clk);
    check(irq == 1'b0, "R9 irq stays clear", irq, 0);

    run_int(8'h80, 8'h01, 1'b0, 1'b0);
    run_int(8'h00, 8'hFF, 1'b0, 1'b1);
    run_int(8'h5A, 8'hC3, 1'b1, 1'b0);

    // R7: idle external edges change nothing
    write_byte(8'h96);
    ext_sel = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sck_in = ~sck_in; sdi = ~sdi;
      repeat (3) @(negedge clk);
    end
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_data == 8'h96 && !busy, "R7 idle ext edges ignored", rd_data, 8'h96);
    check(sck_oe == 1'b0, "R7 oe off when ext selected", sck_oe, 0);
    ext_sel = 1'b0;

    run_ext(8'hC1, 8'h7E);

    for (int t = 0; t < 6; t++) begin
      a = 8'($urandom);
      b = 8'($urandom);
      if (t % 2 == 0) run_int(a, b, t == 2, t == 4);
      else run_ext(a, b);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule